// File: doc/BRIEF.md
# Symmetric Six-Channel PWM Generator

This block drives six PWM lines from one triangle counter that climbs from zero to a programmed period and falls back to zero, so every pulse is centred on the counter peak. Three compare values each serve a pair of neighbouring outputs. A per-output two-bit action code chooses whether that line is high while the counter is below its compare value, is the inverse of that, or is forced to a fixed level.

Compare values and the action word are written into shadow copies. They move into the working copies only when the counter lands on zero while falling, or continuously while the counter is stopped, so software can update a live waveform without tearing a pulse. The arrival at zero also produces a one-cycle event for downstream logic, such as starting a conversion. Two separate gates, a compare enable and a pin enable, must both be high for any line to leave zero.

Top module: `sym_pwm6`

## Requirements
- R1: With `cntEn` high and period P >= 1, the counter starts at 0, steps by one each cycle up to P, then steps down to 0, and repeats with a full cycle of 2P clocks.
- R2: Write address 0 holds the period, addresses 1, 2 and 3 hold the shadow compare values for output pairs {0,1}, {2,3} and {4,5}, and address 4 holds the 12-bit shadow action word, in which output i uses bits [2i+1:2i].
- R3: Action code 2'b10 makes an output 1 exactly while the counter is below its pair's compare value; code 2'b01 gives the inverse.
- R4: Action code 2'b00 holds an output at 0 and code 2'b11 holds it at 1, whatever the counter.
- R5: While the counter runs, shadow compare and action values written in a cycle take effect at the clock edge where the counter reaches 0 while falling, and not earlier.
- R6: `ufPulse` is 1 for exactly the one cycle in which the counter has just reached 0 while falling, and stays 0 when the counter leaves 0 upward.
- R7: All six lines are 0 unless both `cmpEn` and `pinEn` are 1.
- R8: While `cntEn` is 0 the counter is held at 0 and set to count up, no pulse is raised, and the working registers take the shadow values on every edge; on re-enable the count restarts from 0.
- R9: With period 0 the counter stays at 0, no pulse is raised and the working registers are not reloaded while `cntEn` is high.
- R10: After reset the counter, period, shadow and working registers are 0, all lines are 0 and `ufPulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (3) | Register select |
| wrData | input | CNT_W (16) | Write data |
| cntEn | input | 1 | Run the counter |
| cmpEn | input | 1 | Global compare enable |
| pinEn | input | 1 | Output pin enable |
| pwmOut | output | 2*NUM_PAIRS (6) | PWM lines, bit i is output i |
| ufPulse | output | 1 | One-cycle zero-arrival event |

## Verification
The assertions take for granted that the period register is only rewritten while the counter is stopped, so the counter never sits above a freshly shrunk period, and that reset is applied before any write. The bench keeps to this by changing the period only in phases with `cntEn` low, and it sweeps every compare value from 0 to one above the period against a rotating set of action codes while writes land at arbitrary points of the triangle, including cycles just before a reload edge.

// File: rtl/sym_pwm_pkg.sv
package sym_pwm_pkg;

  // Strobes from the counter control to the datapath.
  typedef struct packed {
    logic idle;  // counter stopped: working regs follow shadows
    logic wrap;  // counter lands on zero while falling this edge
  } pwmStrb_t;

  localparam int ACT_HIGH = 2'b10;
  localparam int ACT_LOW  = 2'b01;
  localparam int FORCE_LO = 2'b00;
  localparam int FORCE_HI = 2'b11;

endpackage

// File: rtl/sym_pwm_ctrl.sv
module sym_pwm_ctrl
  import sym_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output pwmStrb_t         strb,
  output logic             ufPulse
);

  logic             dirUp;
  logic [CNT_W-1:0] nxtCnt;
  logic             nxtUp;
  logic             running;
  logic             hitZero;

  assign running = cntEn && (period != '0);

  always_comb begin
    nxtCnt  = cnt;
    nxtUp   = dirUp;
    hitZero = 1'b0;
    if (!running) begin
      nxtCnt = '0;
      nxtUp  = 1'b1;
    end else if (dirUp && (cnt < period)) begin
      nxtCnt = cnt + 1'b1;
    end else if (cnt <= CNT_W'(1)) begin
      nxtCnt  = '0;
      nxtUp   = 1'b1;
      hitZero = 1'b1;
    end else begin
      nxtCnt = cnt - 1'b1;
      nxtUp  = 1'b0;
    end
  end

  assign strb.idle = !cntEn;
  assign strb.wrap = hitZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dirUp   <= 1'b1;
      ufPulse <= 1'b0;
    end else begin
      cnt     <= nxtCnt;
      dirUp   <= nxtUp;
      ufPulse <= hitZero;
    end
  end

  // R1: a rising count below the period advances by exactly one
  p_step_up_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && dirUp && period != '0 && cnt < period) |=> cnt == $past(cnt) + 1'b1);

  // R6: the event coincides with a zero count and never repeats back to back
  p_uf_at_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    ufPulse |-> cnt == '0);
  p_uf_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    ufPulse |=> !ufPulse);

  // R8: a stopped counter sits at zero with no event
  p_stopped_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> (cnt == '0 && !ufPulse));

  // R9: zero period keeps the counter parked
  p_zero_period_r9: assert property (@(posedge clk) disable iff (!rstN)
    (period == '0) |=> (cnt == '0 && !ufPulse));

endmodule

// File: rtl/sym_pwm_dp.sv
module sym_pwm_dp
  import sym_pwm_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_PAIRS = 3,
  parameter int ADDR_W    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [CNT_W-1:0]       wrData,
  input  pwmStrb_t               strb,
  input  logic [CNT_W-1:0]       cnt,
  input  logic                   cmpEn,
  input  logic                   pinEn,
  output logic [CNT_W-1:0]       period,
  output logic [2*NUM_PAIRS-1:0] pwmOut
);

  localparam int NUM_OUT  = 2 * NUM_PAIRS;
  localparam int ACT_W    = 2 * NUM_OUT;
  localparam int ADDR_ACT = NUM_PAIRS + 1;

  logic [CNT_W-1:0]   cmpShd [NUM_PAIRS];
  logic [CNT_W-1:0]   cmpAct [NUM_PAIRS];
  logic [ACT_W-1:0]   actShd;
  logic [ACT_W-1:0]   actAct;
  logic [NUM_OUT-1:0] lvl;
  logic               reload;
  logic               gateOn;

  assign reload = strb.idle || strb.wrap;
  assign gateOn = cmpEn && pinEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period <= '0;
    end else if (wrEn && wrAddr == '0) begin
      period <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actShd <= '0;
      actAct <= '0;
    end else begin
      if (reload) actAct <= actShd;
      if (wrEn && wrAddr == ADDR_W'(ADDR_ACT)) actShd <= wrData[ACT_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpShd[p] <= '0;
        cmpAct[p] <= '0;
      end else begin
        if (reload) cmpAct[p] <= cmpShd[p];
        if (wrEn && wrAddr == ADDR_W'(p + 1)) cmpShd[p] <= wrData;
      end
    end

    // R5: working compare value moves only on a reload strobe
    p_hold_cmp_r5: assert property (@(posedge clk) disable iff (!rstN)
      !reload |=> $stable(cmpAct[p]));
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic       below;
    logic [1:0] code;
    logic       bitLvl;

    assign below = cnt < cmpAct[o / 2];
    assign code  = actAct[2*o +: 2];

    always_comb begin
      case (code)
        2'(ACT_HIGH): bitLvl = below;
        2'(ACT_LOW):  bitLvl = !below;
        2'(FORCE_HI): bitLvl = 1'b1;
        default:      bitLvl = 1'b0;
      endcase
    end

    assign lvl[o] = bitLvl;

    // R4: forced codes win over the counter
    p_force_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
      (gateOn && code == 2'(FORCE_HI)) |-> pwmOut[o]);
    p_force_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
      (code == 2'(FORCE_LO)) |-> !pwmOut[o]);
  end

  assign pwmOut = gateOn ? lvl : '0;

  // R5: action word moves only on a reload strobe
  p_hold_act_r5: assert property (@(posedge clk) disable iff (!rstN)
    !reload |=> $stable(actAct));

endmodule

// File: rtl/sym_pwm6.sv
module sym_pwm6
  import sym_pwm_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_PAIRS = 3,
  localparam int ADDR_W   = $clog2(NUM_PAIRS + 2)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [CNT_W-1:0]       wrData,
  input  logic                   cntEn,
  input  logic                   cmpEn,
  input  logic                   pinEn,
  output logic [2*NUM_PAIRS-1:0] pwmOut,
  output logic                   ufPulse
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  pwmStrb_t         strb;

  sym_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cntEn   (cntEn),
    .period  (period),
    .cnt     (cnt),
    .strb    (strb),
    .ufPulse (ufPulse)
  );

  sym_pwm_dp #(
    .CNT_W     (CNT_W),
    .NUM_PAIRS (NUM_PAIRS),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strb   (strb),
    .cnt    (cnt),
    .cmpEn  (cmpEn),
    .pinEn  (pinEn),
    .period (period),
    .pwmOut (pwmOut)
  );

  // R7: either gate low silences every line
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmpEn && pinEn) |-> pwmOut == '0);

  // R6: an event is only ever raised on a running counter
  p_uf_needs_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    ufPulse |-> $past(cntEn));

endmodule

// File: tb/sym_pwm6_tb.sv
module sym_pwm6_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        cntEn = 1'b0;
  logic        cmpEn = 1'b0;
  logic        pinEn = 1'b0;
  logic [5:0]  pwmOut;
  logic        ufPulse;

  int checks = 0;
  int errors = 0;

  // bench model state
  int          k = 0;
  int          mPer = 0;
  logic [15:0] mCmpS [3];
  logic [15:0] mCmpA [3];
  logic [11:0] mActS = '0;
  logic [11:0] mActA = '0;
  logic        mUf = 1'b0;

  always #4 clk = ~clk;

  sym_pwm6 u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntEn(cntEn), .cmpEn(cmpEn), .pinEn(pinEn), .pwmOut(pwmOut), .ufPulse(ufPulse)
  );

  function automatic int expCnt();
    int t;
    if (!cntEn || mPer == 0) return 0;
    t = k % (2 * mPer);
    return (t <= mPer) ? t : 2 * mPer - t;
  endfunction

  function automatic logic [5:0] expOut();
    logic [5:0] v;
    int c;
    c = expCnt();
    for (int o = 0; o < 6; o++) begin
      logic below;
      below = c < int'(mCmpA[o/2]);
      case (mActA[2*o +: 2])
        2'b10: v[o] = below;
        2'b01: v[o] = !below;
        2'b11: v[o] = 1'b1;
        default: v[o] = 1'b0;
      endcase
    end
    if (!(cmpEn && pinEn)) v = '0;
    return v;
  endfunction

  task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at k=%0d: got %b expected %b", tag, k, got, exp);
    end
  endtask

  // advance one clock, update the model with register semantics, then check
  task automatic tick(string tag);
    logic rel;
    @(posedge clk);
    if (cntEn && mPer != 0) begin
      k++;
      mUf = (k % (2 * mPer)) == 0;
      rel = mUf;
    end else begin
      k = 0;
      mUf = 1'b0;
      rel = !cntEn;
    end
    if (rel) begin
      for (int p = 0; p < 3; p++) mCmpA[p] = mCmpS[p];
      mActA = mActS;
    end
    if (wrEn) begin
      case (wrAddr)
        3'd0: mPer = int'(wrData);
        3'd1: mCmpS[0] = wrData;
        3'd2: mCmpS[1] = wrData;
        3'd3: mCmpS[2] = wrData;
        3'd4: mActS = wrData[11:0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk(tag, pwmOut, expOut());
    chk("R6", {5'b0, ufPulse}, {5'b0, mUf});
  endtask

  task automatic wr(int addr, int data, string tag);
    wrEn = 1'b1;
    wrAddr = 3'(addr);
    wrData = 16'(data);
    tick(tag);
    wrEn = 1'b0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      mCmpS[p] = '0;
      mCmpA[p] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", pwmOut, 6'b0);
    chk("R10", {5'b0, ufPulse}, 6'b0);
    rstN = 1'b1;
    cmpEn = 1'b1;
    pinEn = 1'b1;
    run(2, "R10");

    // configure while stopped (R2, R8)
    wr(0, 5, "R2");
    wr(1, 2, "R2");
    wr(2, 3, "R2");
    wr(3, 6, "R2");
    wr(4, 12'h366, "R2");
    run(2, "R8");

    // free run: triangle and polarity (R1, R3, R4)
    cntEn = 1'b1;
    run(20, "R1");
    run(3, "R3");

    // live update mid-slope, must wait for the zero arrival (R5)
    wr(1, 0, "R5");
    wr(2, 5, "R5");
    wr(3, 1, "R5");
    wr(4, 12'h0F9, "R5");
    run(25, "R5");

    // compare sweep with rotating action codes (R2, R3, R4)
    for (int c = 0; c <= 6; c++) begin
      wr(1, c, "R3");
      wr(2, 6 - c, "R3");
      wr(3, (c * 3) % 7, "R3");
      wr(4, (c * 12'h1B3 + 12'h0A5) & 12'hFFF, "R4");
      run(12, "R2");
    end

    // output gating (R7)
    cmpEn = 1'b0;
    run(11, "R7");
    cmpEn = 1'b1;
    pinEn = 1'b0;
    run(11, "R7");
    pinEn = 1'b1;
    run(4, "R7");

    // stop and restart from zero (R8)
    cntEn = 1'b0;
    wr(1, 4, "R8");
    wr(4, 12'hAAA, "R8");
    run(3, "R8");
    cntEn = 1'b1;
    run(22, "R8");

    // shortest period (R1, R6)
    cntEn = 1'b0;
    wr(0, 1, "R1");
    cntEn = 1'b1;
    run(8, "R1");

    // zero period parks the counter (R9)
    cntEn = 1'b0;
    wr(0, 0, "R9");
    wr(1, 1, "R9");
    cntEn = 1'b1;
    run(2, "R9");
    wr(1, 0, "R9");
    run(10, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule